// File: doc/BRIEF.md
# Comma-Aligned Serial-to-Character Converter with Character-Rate Clock

This block sits after a clock-recovery front end. It takes a retimed serial bit stream, qualified by a bit-rate enable, and rebuilds 10-bit line characters from it. The earliest bit of each character lands in output bit 0. The block watches the last ten received bits for the 7-bit comma signature. When it finds one at any bit offset, it moves the character boundary so that the comma character comes out whole, with its comma flag set, and later characters follow every ten bits from that point.

Alongside the data, the block divides the tick stream down to a pair of complementary character-rate clocks. A mode input selects one tenth of the bit rate (one character per clock period) or one twentieth (one character per clock half-period, so each edge carries a character). The line can go quiet because the bit enables stop or the data stops changing. When that happens, a reference tick that runs nominally at the bit rate takes over as the divider's source, and downstream logic keeps getting clocks. The switch never produces a half-period shorter than the selected one.

All logic runs on one system clock with a synchronous, active-high reset. Line decoding and clock recovery are done elsewhere.

Top module: `sdes_rx_align`

## Requirements
- R1: Serial bits fill the character in arrival order. The first bit of a character appears at `char_out[0]` and the tenth at `char_out[9]`.
- R2: A comma is recognised when, in arrival order, the first seven bits of a 10-bit window are 0,0,1,1,1,1,1 (`char_out[6:0] == 7'h7C`). Bits 7 to 9 do not affect detection. `comma_flag` is 1 with a comma character and 0 with any other character.
- R3: A comma found at any bit offset ends the current character there. The comma character is presented whole, and the next character follows after exactly ten more bits.
- R4: `char_stb` pulses for one cycle, one clock after the bit tick that completes a character. `char_out` and `comma_flag` hold their values until the next pulse.
- R5: `rclk_n` is always the inverse of `rclk_p`.
- R6: With `rate_fast` = 1 the output clock changes level every 5 source ticks (period of 10 bits). With `rate_fast` = 0 it changes level every 10 source ticks (period of 20 bits). With no source tick the clocks hold their level.
- R7: Loss of input is declared after 64 reference ticks with no data transition seen on a bit tick. From then on, the reference tick drives the divider. Until loss is declared, the reference tick has no effect on the clocks.
- R8: A data transition on a bit tick clears loss of input, and the bit tick then drives the divider again.
- R9: With `rate_fast` = 0 and a continuous aligned stream, exactly one character is presented per clock half-period.
- R10: Reset sets the character boundary offset to zero, `rclk_p` to 0, `rclk_n` to 1, `char_out` to 0, and `comma_flag` and `char_stb` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle enable per received serial bit |
| ser_in | input | 1 | Retimed serial data, valid when `bit_tick` is 1 |
| ref_tick | input | 1 | Local reference enable, nominally at the bit rate |
| rate_fast | input | 1 | 1: clocks at one tenth of the bit rate; 0: one twentieth |
| char_out | output | 10 | Last assembled character, first-received bit in bit 0 |
| char_stb | output | 1 | One-cycle pulse when `char_out` is updated |
| comma_flag | output | 1 | The current `char_out` is a comma character |
| rclk_p | output | 1 | Character-rate clock |
| rclk_n | output | 1 | Complement of `rclk_p` |

## Verification
A wrong boundary offset shows up as a rotated or mixed character within ten bit ticks, or as a comma that arrives without its flag. It appears as soon as the next character is presented. A corrupted divider count shows up as a half-period of the wrong length at the next level change of `rclk_p`. A wrong loss-of-input state shows up in two ways: the clocks freeze when the bit ticks stop, or the reference ticks move the clocks while the line is healthy. Either is visible within one half-period once the 64-tick window has passed.

// File: rtl/sdes_pkg.sv
package sdes_pkg;

   // Which tick drives the character-rate divider.
   typedef enum logic {
      SRC_LINE = 1'b0,
      SRC_REF  = 1'b1
   } tick_src_e;

   // Half-period length in ticks for a given full division ratio.
   function automatic int unsigned half_of(input int unsigned ratio);
      return ratio / 2;
   endfunction

endpackage

// File: rtl/sdes_frame.sv
module sdes_frame #(
   parameter int unsigned CHAR_W  = 10,
   parameter int unsigned COMMA_W = 7,
   parameter logic [COMMA_W-1:0] COMMA_PAT = 7'h7C
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_tick,
   input  logic              ser_in,
   output logic [CHAR_W-1:0] char_q,
   output logic              comma_q,
   output logic              stb_q
);

   localparam int unsigned CNT_W = $clog2(CHAR_W);
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CHAR_W - 1);

   logic [CHAR_W-1:0] win_q;
   logic [CHAR_W-1:0] win_nx;
   logic [CNT_W-1:0]  pos_q;
   logic              comma_hit;

   // Newest bit enters at the top, so the oldest of ten sits in bit 0.
   assign win_nx = {ser_in, win_q[CHAR_W-1:1]};

   generate
      if (COMMA_W == CHAR_W) begin : g_full_cmp
         assign comma_hit = (win_nx == COMMA_PAT);
      end else begin : g_part_cmp
         assign comma_hit = (win_nx[COMMA_W-1:0] == COMMA_PAT);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         // All ones: a partly filled window can never look like a comma.
         win_q   <= '1;
         pos_q   <= '0;
         char_q  <= '0;
         comma_q <= 1'b0;
         stb_q   <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         if (bit_tick) begin
            win_q <= win_nx;
            if (comma_hit || (pos_q == LAST_POS)) begin
               pos_q   <= '0;
               char_q  <= win_nx;
               comma_q <= comma_hit;
               stb_q   <= 1'b1;
            end else begin
               pos_q <= pos_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sdes_los.sv
module sdes_los #(
   parameter int unsigned QUIET_LIMIT = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_tick,
   input  logic ser_in,
   input  logic ref_tick,
   output logic lost_q
);

   localparam int unsigned RUN_W = $clog2(QUIET_LIMIT + 1);
   localparam logic [RUN_W-1:0] RUN_END = RUN_W'(QUIET_LIMIT - 1);

   logic [RUN_W-1:0] run_q;
   logic             prev_q;
   logic             edge_seen;

   assign edge_seen = bit_tick && (ser_in != prev_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b0;
         run_q  <= '0;
         lost_q <= 1'b0;
      end else begin
         if (bit_tick) begin
            prev_q <= ser_in;
         end
         if (edge_seen) begin
            run_q  <= '0;
            lost_q <= 1'b0;
         end else if (ref_tick) begin
            if (run_q == RUN_END) begin
               lost_q <= 1'b1;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sdes_clkdiv.sv
module sdes_clkdiv
   import sdes_pkg::*;
#(
   parameter int unsigned DIV_SLOW = 20,
   parameter int unsigned DIV_FAST = 10,
   parameter bit          N_AS_FLOP = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic rate_fast,
   output logic clk_p,
   output logic clk_n
);

   localparam int unsigned H_SLOW = half_of(DIV_SLOW);
   localparam int unsigned H_FAST = half_of(DIV_FAST);
   localparam int unsigned PC_W   = $clog2(H_SLOW);

   logic [PC_W-1:0] phase_q;
   logic [PC_W-1:0] phase_end;
   logic            flip;

   assign phase_end = rate_fast ? PC_W'(H_FAST - 1) : PC_W'(H_SLOW - 1);
   assign flip      = tick && (phase_q >= phase_end);

   // Phase is carried across source changes: a half-period never shrinks.
   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= '0;
         clk_p   <= 1'b0;
      end else if (tick) begin
         if (flip) begin
            phase_q <= '0;
            clk_p   <= ~clk_p;
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end
   end

   generate
      if (N_AS_FLOP) begin : g_n_flop
         always_ff @(posedge clk) begin
            if (rst) begin
               clk_n <= 1'b1;
            end else if (flip) begin
               clk_n <= clk_p;
            end
         end
      end else begin : g_n_inv
         assign clk_n = ~clk_p;
      end
   endgenerate

endmodule

// File: rtl/sdes_rx_align.sv
module sdes_rx_align
   import sdes_pkg::*;
#(
   parameter int unsigned CHAR_W      = 10,
   parameter int unsigned COMMA_W     = 7,
   parameter logic [COMMA_W-1:0] COMMA_PAT = 7'h7C,
   parameter int unsigned QUIET_LIMIT = 64,
   parameter int unsigned DIV_SLOW    = 20,
   parameter int unsigned DIV_FAST    = 10,
   parameter bit          N_AS_FLOP   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_tick,
   input  logic              ser_in,
   input  logic              ref_tick,
   input  logic              rate_fast,
   output logic [CHAR_W-1:0] char_out,
   output logic              char_stb,
   output logic              comma_flag,
   output logic              rclk_p,
   output logic              rclk_n
);

   generate
      if (COMMA_W > CHAR_W) begin : g_bad_comma
         $error("sdes_rx_align: comma wider than character");
      end
      if (CHAR_W < 2) begin : g_bad_char
         $error("sdes_rx_align: character width below 2");
      end
      if ((DIV_SLOW % 2) != 0 || (DIV_FAST % 2) != 0) begin : g_bad_div
         $error("sdes_rx_align: division ratios must be even");
      end
      if (DIV_FAST < 4 || DIV_FAST > DIV_SLOW) begin : g_bad_order
         $error("sdes_rx_align: need 4 <= DIV_FAST <= DIV_SLOW");
      end
      if (QUIET_LIMIT < 2) begin : g_bad_quiet
         $error("sdes_rx_align: quiet limit below 2");
      end
   endgenerate

   logic      lost;
   logic      tick_src;
   tick_src_e src_sel;

   sdes_frame #(
      .CHAR_W   (CHAR_W),
      .COMMA_W  (COMMA_W),
      .COMMA_PAT(COMMA_PAT)
   ) u_frame (
      .clk     (clk),
      .rst     (rst),
      .bit_tick(bit_tick),
      .ser_in  (ser_in),
      .char_q  (char_out),
      .comma_q (comma_flag),
      .stb_q   (char_stb)
   );

   sdes_los #(
      .QUIET_LIMIT(QUIET_LIMIT)
   ) u_los (
      .clk     (clk),
      .rst     (rst),
      .bit_tick(bit_tick),
      .ser_in  (ser_in),
      .ref_tick(ref_tick),
      .lost_q  (lost)
   );

   assign src_sel  = lost ? SRC_REF : SRC_LINE;
   assign tick_src = (src_sel == SRC_REF) ? ref_tick : bit_tick;

   sdes_clkdiv #(
      .DIV_SLOW (DIV_SLOW),
      .DIV_FAST (DIV_FAST),
      .N_AS_FLOP(N_AS_FLOP)
   ) u_div (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick_src),
      .rate_fast(rate_fast),
      .clk_p    (rclk_p),
      .clk_n    (rclk_n)
   );

endmodule

// File: rtl/sdes_rx_align_chk.sv
module sdes_rx_align_chk #(
   parameter int unsigned CHAR_W  = 10,
   parameter int unsigned COMMA_W = 7,
   parameter logic [COMMA_W-1:0] COMMA_PAT = 7'h7C
) (
   input logic              clk,
   input logic              rst,
   input logic              bit_tick,
   input logic              tick_src,
   input logic [CHAR_W-1:0] char_out,
   input logic              char_stb,
   input logic              comma_flag,
   input logic              rclk_p,
   input logic              rclk_n
);

   // R5: the two clocks are always opposite.
   p_compl_r5: assert property (@(posedge clk) disable iff (rst)
      rclk_n == !rclk_p);

   // R10: the first cycle after reset shows the known clock phase and no strobe.
   p_rst_state_r10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!rclk_p && rclk_n && !char_stb && !comma_flag));

   // R4: a strobe always follows a bit tick.
   p_stb_tick_r4: assert property (@(posedge clk) disable iff (rst)
      char_stb |-> $past(bit_tick));

   // R2: a flagged character carries the comma signature in its low bits.
   p_comma_pat_r2: assert property (@(posedge clk) disable iff (rst)
      comma_flag |-> (char_out[COMMA_W-1:0] == COMMA_PAT));

   // R4: the flag only moves together with a new character.
   p_flag_upd_r4: assert property (@(posedge clk) disable iff (rst)
      !$stable(comma_flag) |-> char_stb);

   // R6: without a source tick the clock holds its level.
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !tick_src |=> $stable(rclk_p));

endmodule

bind sdes_rx_align sdes_rx_align_chk #(
   .CHAR_W   (CHAR_W),
   .COMMA_W  (COMMA_W),
   .COMMA_PAT(COMMA_PAT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .bit_tick  (bit_tick),
   .tick_src  (tick_src),
   .char_out  (char_out),
   .char_stb  (char_stb),
   .comma_flag(comma_flag),
   .rclk_p    (rclk_p),
   .rclk_n    (rclk_n)
);

// File: tb/sdes_rx_align_tb.sv
module sdes_rx_align_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bit_tick = 1'b0;
   logic       ser_in = 1'b0;
   logic       ref_tick = 1'b0;
   logic       rate_fast = 1'b0;
   logic [9:0] char_out;
   logic       char_stb;
   logic       comma_flag;
   logic       rclk_p;
   logic       rclk_n;

   always #2.5 clk = ~clk;

   sdes_rx_align u_dut (
      .clk       (clk),
      .rst       (rst),
      .bit_tick  (bit_tick),
      .ser_in    (ser_in),
      .ref_tick  (ref_tick),
      .rate_fast (rate_fast),
      .char_out  (char_out),
      .char_stb  (char_stb),
      .comma_flag(comma_flag),
      .rclk_p    (rclk_p),
      .rclk_n    (rclk_n)
   );

   // {expected comma flag, character}; bit 0 is sent first.
   localparam int NVEC = 12;
   localparam logic [10:0] VEC [0:NVEC-1] = '{
      11'h155, 11'h2AA, 11'h67C, 11'h155, 11'h0F0, 11'h07D,
      11'h155, 11'h57C, 11'h2AA, 11'h07E, 11'h0C3, 11'h155
   };

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Port monitor, sampling away from the active edge.
   logic [10:0] capq[$];
   int  cyc = 0, tog = 0, stb_n = 0, nmis = 0, last_tc = 0, last_iv = 0;
   logic prev_p = 1'b0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (!rst) begin
         if (rclk_p != prev_p) begin
            tog = tog + 1;
            last_iv = cyc - last_tc;
            last_tc = cyc;
         end
         prev_p = rclk_p;
         if (rclk_n === rclk_p) nmis = nmis + 1;
         if (char_stb) begin
            stb_n = stb_n + 1;
            capq.push_back({comma_flag, char_out});
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_bad = n_bad + 1;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      ser_in   = b;
      bit_tick = 1'b1;
   endtask

   task automatic send_char(input logic [9:0] c);
      for (int i = 0; i < 10; i++) send_bit(c[i]);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_tick = 1'b0;
      end
   endtask

   task automatic clear_mon();
      @(posedge clk);
      capq.delete();
      tog   = 0;
      stb_n = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk = n_chk + 1;
         n_bad = n_bad + 1;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R10 reset state
      chk(rclk_p == 1'b0, "R10", "rclk_p in reset", int'(rclk_p), 0);
      chk(rclk_n == 1'b1, "R10", "rclk_n in reset", int'(rclk_n), 1);
      chk(char_out == 10'h0, "R10", "char_out in reset", int'(char_out), 0);
      chk(char_stb == 1'b0, "R10", "char_stb in reset", int'(char_stb), 0);
      chk(comma_flag == 1'b0, "R10", "comma_flag in reset", int'(comma_flag), 0);
      rst = 1'b0;
      ref_tick = 1'b1;

      // Vector table: R1 bit order, R2 comma recognition, R10 zero offset.
      clear_mon();
      for (int v = 0; v < NVEC; v++) send_char(VEC[v][9:0]);
      idle(3);
      chk(capq.size() == NVEC, "R1", "character count", capq.size(), NVEC);
      for (int v = 0; v < NVEC; v++) begin
         if (v < capq.size())
            chk(capq[v] == VEC[v], (VEC[v][10] ? "R2" : "R1"), "table character",
                int'(capq[v]), int'(VEC[v]));
      end
      // R9: slow mode, one character per half-period; R6 interval.
      chk(tog == NVEC, "R9", "half-periods over table", tog, NVEC);
      chk(stb_n == tog, "R9", "characters per half-periods", stb_n, tog);
      chk(last_iv == 10, "R6", "slow half-period cycles", last_iv, 10);

      // R6 fast mode.
      rate_fast = 1'b1;
      clear_mon();
      for (int v = 0; v < 6; v++) send_char(VEC[v][9:0]);
      idle(3);
      chk(tog == 12, "R6", "fast half-periods", tog, 12);
      chk(last_iv == 5, "R6", "fast half-period cycles", last_iv, 5);
      chk(stb_n == 6, "R4", "one strobe per character", stb_n, 6);
      rate_fast = 1'b0;

      // R3 realignment at every offset.
      for (int off = 1; off < 10; off++) begin
         clear_mon();
         for (int k = 0; k < off; k++) send_bit(((k % 2) == 0) ? 1'b1 : 1'b0);
         send_char(10'h27C);
         send_char(10'h155);
         idle(3);
         if (capq.size() >= 2) begin
            chk(capq[capq.size()-2] == 11'h67C, "R3", $sformatf("comma after offset %0d", off),
                int'(capq[capq.size()-2]), 'h67C);
            chk(capq[capq.size()-1] == 11'h155, "R3", $sformatf("next char after offset %0d", off),
                int'(capq[capq.size()-1]), 'h155);
         end else begin
            chk(1'b0, "R3", "realign captures", capq.size(), 2);
         end
      end

      // R7 loss of input: bit ticks stop, reference keeps running.
      ser_in = 1'b0;
      clear_mon();
      bit_tick = 1'b0;
      ref_tick = 1'b1;
      repeat (45) @(negedge clk);
      chk(tog == 0, "R7", "no toggles before loss declared", tog, 0);
      repeat (200) @(negedge clk);
      chk(tog >= 10, "R7", "toggles from reference", tog, 10);
      chk(last_iv == 10, "R7", "reference half-period cycles", last_iv, 10);

      // R8 recovery: transitions on bit ticks bring the line source back.
      clear_mon();
      ref_tick = 1'b0;
      for (int v = 0; v < 4; v++) send_char(10'h155);
      idle(2);
      chk(tog >= 3, "R8", "toggles from bit ticks", tog, 3);
      chk(last_iv == 10, "R8", "line half-period cycles", last_iv, 10);

      // R7: reference ignored while the line is healthy.
      clear_mon();
      ref_tick = 1'b1;
      repeat (30) @(negedge clk);
      chk(tog == 0, "R7", "reference ignored without loss", tog, 0);

      chk(nmis == 0, "R5", "cycles with equal clock levels", nmis, 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule